// File: doc/BRIEF.md
# Privilege Check and Program-Check Trap Entry

This block sits at the commit point of an in-order core. Each cycle it may receive one decoded instruction: the operation class, the top bit of its special-register number, an illegal-instruction flag, the instruction's address, the address that sequential execution would fetch next, and the current 64-bit machine state word. It decides, in the same cycle, whether that instruction is allowed to retire.

An instruction traps when it is illegal, or when it is privileged while the machine state word says the core runs in problem (user) state. On a trap the block does four things. It holds back the instruction's writeback. It redirects fetch to the program-check vector. It presents the fixed interrupt-entry machine state for the core to load. At the next clock edge it captures the instruction address in save register 0, and in save register 1 it captures the old machine state with one cause bit forced high. Bit positions are counted big-endian: position p is data bit 63-p. All positions are parameters.

Top module: `priv_trap_unit`

## Requirements
- R1: After reset, `srr0` and `srr1` read zero, and while `instValid` is low `trapTaken` and `commitEn` stay low.
- R2: Operation classes 1, 2, 3, 4 and 5 (halt-attention, read state, write state, write state doubleword, return from interrupt) trap when the problem-state bit (position 49, data bit 14) of `msrIn` is 1, and the recorded cause is the privileged cause bit (position 45, data bit 18).
- R3: Operation classes 6 and 7 (special-register read and write) are privileged only when `sprHigh` is 1; with `sprHigh` at 0 they retire even in problem state.
- R4: A privileged operation with the problem-state bit at 0 does not trap and retires with `commitEn` high.
- R5: An illegal instruction traps whatever the problem-state bit is, and its cause is the illegal cause bit (position 44, data bit 19). When an instruction is both illegal and a privileged violation, only the privileged cause bit is forced.
- R6: `nextPc` is the vector 0x700 in a trap cycle and `seqNextPc` otherwise.
- R7: At the clock edge that ends a trap cycle, `srr0` takes `curPc`, and `srr1` takes `msrIn` with the selected cause bit forced to 1.
- R8: In a trap cycle `msrNext` is `msrIn` with positions 58, 59, 52, 55, 48, 62, 31, 38, 40, 49, 50, 61, 53, 54 and 5 cleared and positions 0 and 63 set, all other bits kept. In any other cycle `msrNext` equals `msrIn`.
- R9: A trapped instruction has `commitEn` low. A valid instruction that does not trap has `commitEn` high. `trapTaken` is high only in a cycle with `instValid` high.
- R10: `srr0` and `srr1` keep their values across every cycle that does not trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | An instruction is presented for retirement this cycle |
| opClass | input | 4 | Decoded operation class (0 = ordinary, 1..7 as in R2/R3) |
| sprHigh | input | 1 | Top bit of the special-register number (instruction bit 20) |
| illegal | input | 1 | Decoder flagged the instruction as illegal |
| curPc | input | 64 | Address of the presented instruction |
| seqNextPc | input | 64 | Fetch address if the instruction retires normally |
| msrIn | input | 64 | Current machine state word |
| trapTaken | output | 1 | Trap taken this cycle |
| commitEn | output | 1 | Instruction may write back its results |
| nextPc | output | 64 | Next fetch address |
| msrNext | output | 64 | Machine state to load at the end of this cycle |
| srr0 | output | 64 | Save register 0 (trapping instruction address) |
| srr1 | output | 64 | Save register 1 (saved machine state plus cause bit) |

## Verification
The assertions check on every cycle that an illegal instruction always traps, that a trap names exactly one cause, and that an idle cycle neither traps nor commits. They also check that supervisor-state legal instructions pass, that the save registers take the address one edge after a trap and hold otherwise, and that the entry state always leaves problem state. The bench scenarios are needed to show the decode of each operation class, the gating of special-register accesses by their high bit, the priority of the privileged cause over the illegal one, and the exact bit pattern of the entry state and of the saved state for varied machine state words.

// File: rtl/priv_trap_pkg.sv
package priv_trap_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OPC_ORDINARY  = 4'd0,
    OPC_ATTN      = 4'd1,
    OPC_READ_ST   = 4'd2,
    OPC_WRITE_ST  = 4'd3,
    OPC_WRITE_STD = 4'd4,
    OPC_RET_INT   = 4'd5,
    OPC_SPR_READ  = 4'd6,
    OPC_SPR_WRITE = 4'd7
  } opClass_e;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic trap;
    logic causePriv;
    logic causeIll;
    logic commit;
  } trapStrobe_t;

endpackage

// File: rtl/priv_trap_ctrl.sv
module priv_trap_ctrl
  import priv_trap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [OP_W-1:0]   opClass,
  input  logic              sprHigh,
  input  logic              illegal,
  input  logic              msrPr,
  output trapStrobe_t       strobe
);

  logic privOp;
  logic privFault;
  logic illFault;

  // Which operation classes need supervisor state
  always_comb begin
    unique case (opClass_e'(opClass))
      OPC_ATTN, OPC_READ_ST, OPC_WRITE_ST,
      OPC_WRITE_STD, OPC_RET_INT:      privOp = 1'b1;
      OPC_SPR_READ, OPC_SPR_WRITE:     privOp = sprHigh;
      default:                         privOp = 1'b0;
    endcase
  end

  assign privFault = instValid && privOp && msrPr;
  assign illFault  = instValid && illegal;

  // Privilege violation is checked first and wins the cause
  always_comb begin
    strobe.trap      = privFault || illFault;
    strobe.causePriv = privFault;
    strobe.causeIll  = illFault && !privFault;
    strobe.commit    = instValid && !(privFault || illFault);
  end

  AST_ILLEGAL_TRAPS: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && illegal) |-> strobe.trap); // R5

  AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.trap |-> ($countones({strobe.causePriv, strobe.causeIll}) == 1)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |-> (!strobe.trap && !strobe.commit)); // R9

  AST_SUPERVISOR_PASSES: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !msrPr && !illegal) |-> (strobe.commit && !strobe.trap)); // R4

endmodule

// File: rtl/priv_trap_dp.sv
module priv_trap_dp
  import priv_trap_pkg::*;
#(
  parameter int          XLEN          = 64,
  parameter logic [63:0] VECTOR        = 64'h700,
  parameter int          CLR_N         = 15,
  parameter int          CLR_POS [CLR_N] = '{58, 59, 52, 55, 48, 62, 31, 38, 40, 49, 50, 61, 53, 54, 5},
  parameter int          SET_N         = 2,
  parameter int          SET_POS [SET_N] = '{0, 63},
  parameter int          PR_POS        = 49,
  parameter int          PRIV_CAUSE_POS = 44 + 1,
  parameter int          ILL_CAUSE_POS  = 44
)(
  input  logic            clk,
  input  logic            rstN,
  input  trapStrobe_t     strobe,
  input  logic [XLEN-1:0] curPc,
  input  logic [XLEN-1:0] seqNextPc,
  input  logic [XLEN-1:0] msrIn,
  output logic [XLEN-1:0] nextPc,
  output logic [XLEN-1:0] msrNext,
  output logic [XLEN-1:0] srr0,
  output logic [XLEN-1:0] srr1
);

  function automatic bit inClrList(int p);
    bit hit = 1'b0;
    for (int i = 0; i < CLR_N; i++) if (CLR_POS[i] == p) hit = 1'b1;
    return hit;
  endfunction

  function automatic bit inSetList(int p);
    bit hit = 1'b0;
    for (int i = 0; i < SET_N; i++) if (SET_POS[i] == p) hit = 1'b1;
    return hit;
  endfunction

  // Masks in data-bit order; position p maps to data bit XLEN-1-p
  logic [XLEN-1:0] clrMask, setMask, privMask, illMask, prMask;

  for (genvar gb = 0; gb < XLEN; gb++) begin : g_mask
    assign clrMask[gb]  = inClrList(XLEN - 1 - gb);
    assign setMask[gb]  = inSetList(XLEN - 1 - gb);
    assign privMask[gb] = ((XLEN - 1 - gb) == PRIV_CAUSE_POS);
    assign illMask[gb]  = ((XLEN - 1 - gb) == ILL_CAUSE_POS);
    assign prMask[gb]   = ((XLEN - 1 - gb) == PR_POS);
  end

  logic [XLEN-1:0] entryMsr;
  logic [XLEN-1:0] savedMsr;

  assign entryMsr = (msrIn & ~clrMask) | setMask;
  assign savedMsr = msrIn | (strobe.causePriv ? privMask : '0)
                          | (strobe.causeIll  ? illMask  : '0);

  assign nextPc  = strobe.trap ? VECTOR[XLEN-1:0] : seqNextPc;
  assign msrNext = strobe.trap ? entryMsr : msrIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srr0 <= '0;
      srr1 <= '0;
    end else if (strobe.trap) begin
      srr0 <= curPc;
      srr1 <= savedMsr;
    end
  end

  AST_SAVE_PC: assert property (@(posedge clk) disable iff (!rstN)
    strobe.trap |=> (srr0 == $past(curPc))); // R7

  AST_SAVE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.trap |=> ($stable(srr0) && $stable(srr1))); // R10

  AST_ILL_CAUSE_SAVED: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.trap && strobe.causeIll) |=> ((srr1 & illMask) != '0)); // R5

  AST_ENTRY_LEAVES_PROBLEM: assert property (@(posedge clk) disable iff (!rstN)
    strobe.trap |-> ((msrNext & prMask) == '0)); // R8

endmodule

// File: rtl/priv_trap_unit.sv
module priv_trap_unit
  import priv_trap_pkg::*;
#(
  parameter int          XLEN           = 64,
  parameter logic [63:0] VECTOR         = 64'h700,
  parameter int          PR_POS         = 49,
  parameter int          PRIV_CAUSE_POS = 45,
  parameter int          ILL_CAUSE_POS  = 44
)(
  input  logic            clk,
  input  logic            rstN,
  input  logic            instValid,
  input  logic [3:0]      opClass,
  input  logic            sprHigh,
  input  logic            illegal,
  input  logic [XLEN-1:0] curPc,
  input  logic [XLEN-1:0] seqNextPc,
  input  logic [XLEN-1:0] msrIn,
  output logic            trapTaken,
  output logic            commitEn,
  output logic [XLEN-1:0] nextPc,
  output logic [XLEN-1:0] msrNext,
  output logic [XLEN-1:0] srr0,
  output logic [XLEN-1:0] srr1
);

  localparam int PR_IDX = XLEN - 1 - PR_POS;

  trapStrobe_t strobe;

  priv_trap_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .instValid (instValid),
    .opClass   (opClass),
    .sprHigh   (sprHigh),
    .illegal   (illegal),
    .msrPr     (msrIn[PR_IDX]),
    .strobe    (strobe)
  );

  priv_trap_dp #(
    .XLEN           (XLEN),
    .VECTOR         (VECTOR),
    .PR_POS         (PR_POS),
    .PRIV_CAUSE_POS (PRIV_CAUSE_POS),
    .ILL_CAUSE_POS  (ILL_CAUSE_POS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .curPc     (curPc),
    .seqNextPc (seqNextPc),
    .msrIn     (msrIn),
    .nextPc    (nextPc),
    .msrNext   (msrNext),
    .srr0      (srr0),
    .srr1      (srr1)
  );

  assign trapTaken = strobe.trap;
  assign commitEn  = strobe.commit;

endmodule

// File: tb/priv_trap_unit_bench.sv
module priv_trap_unit_bench;

  localparam int CLK_PERIOD = 10;

  // Masks from the requirements (data bit = 63 - position)
  localparam logic [63:0] CLR_M  = 64'h0400_0001_0280_EF36; // R8 cleared positions
  localparam logic [63:0] SET_M  = 64'h8000_0000_0000_0001; // R8 positions 0 and 63
  localparam logic [63:0] PRIV_M = 64'h0000_0000_0004_0000; // position 45
  localparam logic [63:0] ILL_M  = 64'h0000_0000_0008_0000; // position 44
  localparam logic [63:0] PR_M   = 64'h0000_0000_0000_4000; // position 49
  localparam logic [63:0] VEC    = 64'h700;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [3:0]  opClass = 4'd0;
  logic        sprHigh = 1'b0;
  logic        illegal = 1'b0;
  logic [63:0] curPc = '0;
  logic [63:0] seqNextPc = '0;
  logic [63:0] msrIn = '0;
  logic        trapTaken, commitEn;
  logic [63:0] nextPc, msrNext, srr0, srr1;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  priv_trap_unit u_priv_trap_unit (
    .clk(clk), .rstN(rstN), .instValid(instValid), .opClass(opClass),
    .sprHigh(sprHigh), .illegal(illegal), .curPc(curPc), .seqNextPc(seqNextPc),
    .msrIn(msrIn), .trapTaken(trapTaken), .commitEn(commitEn), .nextPc(nextPc),
    .msrNext(msrNext), .srr0(srr0), .srr1(srr1)
  );

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Present one instruction for one cycle; check comb outputs, then state
  task automatic runInst(string req, logic [3:0] opc, logic spr, logic ill,
                         logic [63:0] pc, logic [63:0] msr, logic expTrap,
                         logic [63:0] expCause);
    logic [63:0] oldS0, oldS1;
    @(negedge clk);
    oldS0 = srr0; oldS1 = srr1;
    instValid = 1'b1; opClass = opc; sprHigh = spr; illegal = ill;
    curPc = pc; seqNextPc = pc + 64'd4; msrIn = msr;
    #1;
    check(req, "trapTaken", {63'd0, trapTaken}, {63'd0, expTrap});
    check("R9", "commitEn", {63'd0, commitEn}, {63'd0, !expTrap});
    check("R6", "nextPc", nextPc, expTrap ? VEC : pc + 64'd4);
    check("R8", "msrNext", msrNext, expTrap ? ((msr & ~CLR_M) | SET_M) : msr);
    @(negedge clk);
    instValid = 1'b0; illegal = 1'b0;
    if (expTrap) begin
      check("R7", "srr0", srr0, pc);
      check("R7", "srr1", srr1, msr | expCause);
    end else begin
      check("R10", "srr0 held", srr0, oldS0);
      check("R10", "srr1 held", srr1, oldS1);
    end
  endtask

  task automatic testReset();
    #1;
    check("R1", "srr0 reset", srr0, 64'd0);
    check("R1", "srr1 reset", srr1, 64'd0);
    check("R1", "trapTaken idle", {63'd0, trapTaken}, 64'd0);
    check("R1", "commitEn idle", {63'd0, commitEn}, 64'd0);
  endtask

  task automatic testPrivInProblem();
    logic [63:0] m;
    m = 64'hA5A5_5A5A_F0F0_C3C3; // problem-state bit set
    for (int k = 1; k <= 5; k++)
      runInst("R2", 4'(k), 1'b0, 1'b0, 64'h1000 + 64'(k*16), m ^ 64'(k << 40), 1'b1, PRIV_M);
  endtask

  task automatic testSupervisor();
    for (int k = 1; k <= 7; k++)
      runInst("R4", 4'(k), 1'b1, 1'b0, 64'h2000 + 64'(k*8), 64'hFFFF_FFFF_FFFF_BFFF, 1'b0, 64'd0);
  endtask

  task automatic testSprGate();
    runInst("R3", 4'd6, 1'b0, 1'b0, 64'h3000, PR_M, 1'b0, 64'd0);
    runInst("R3", 4'd7, 1'b0, 1'b0, 64'h3004, PR_M | 64'h10, 1'b0, 64'd0);
    runInst("R3", 4'd6, 1'b1, 1'b0, 64'h3008, PR_M, 1'b1, PRIV_M);
    runInst("R3", 4'd7, 1'b1, 1'b0, 64'h300C, 64'hFFFF_FFFF_FFF3_FFFF, 1'b1, PRIV_M);
  endtask

  task automatic testIllegal();
    runInst("R5", 4'd0, 1'b0, 1'b1, 64'h4000, 64'h0123_4567_89AB_0000, 1'b1, ILL_M);
    runInst("R5", 4'd8, 1'b0, 1'b1, 64'h4010, PR_M | 64'h1, 1'b1, ILL_M);
    runInst("R5", 4'd2, 1'b0, 1'b1, 64'h4020, PR_M, 1'b1, PRIV_M); // both: priv wins
    check("R5", "illegal bit not forced", srr1 & ILL_M, 64'd0);
  endtask

  task automatic testOrdinaryAndIdle();
    runInst("R9", 4'd0, 1'b1, 1'b0, 64'h5000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 64'd0);
    runInst("R9", 4'd12, 1'b1, 1'b0, 64'h5004, PR_M, 1'b0, 64'd0);
    // idle cycle with illegal flag up must not trap or touch the save registers
    @(negedge clk);
    illegal = 1'b1; opClass = 4'd1; msrIn = PR_M; curPc = 64'hDEAD;
    #1;
    check("R9", "idle trapTaken", {63'd0, trapTaken}, 64'd0);
    check("R9", "idle commitEn", {63'd0, commitEn}, 64'd0);
    check("R8", "idle msrNext", msrNext, PR_M);
    @(negedge clk);
    check("R10", "idle srr0 held", srr0, 64'h4020);
    illegal = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testPrivInProblem();
    testSupervisor();
    testSprGate();
    testIllegal();
    testOrdinaryAndIdle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule